// File: doc/BRIEF.md
# Serial EEPROM Slave with Block Protection

This block behaves like a small serial-bus EEPROM seen from the bus side. A fast system clock samples the four serial pins (select, serial clock, data in, hold). The block finds the rising edges of the serial clock on its own. It decodes an 8-bit instruction, collects a 16-bit address and then serves byte reads and writes against an internal byte array. A status register holds a write-enable latch and a two-bit protection field. Results leave on one serial data output.

A bus master selects the block and shifts in an instruction, MSB first. Array reads stream bytes out without end and wrap at the top of the array. Array writes advance inside a 128-byte page and wrap back to its start. The protection field can shield the upper quarter, the upper half or the whole array. The array depth is a power-of-two parameter from 256 bytes to 64 KB, and the address taken from the bus is masked to that depth. A test-only side port loads and inspects the array directly. There is no data stream with flow control here: the serial pins follow the bus protocol, and the side port is plain.

Top module: `spi_eeprom_slave`

## Requirements
- R1: While the synchronised hold input is low, the block changes no state, writes no array byte and keeps its data output steady. The last seen serial-clock level is still tracked, so a clock that rose while hold was low is not taken as a new edge afterwards.
- R2: After reset, and whenever select is high with hold high, the data output is 1, the bit count and instruction clear and the block waits for a new instruction. A transfer cut short this way has no effect.
- R3: Instruction, address and write data enter MSB first, one bit per rising serial-clock edge while select is low. Each pin passes a two-stage synchroniser, so any state or output change lands on the third rising system-clock edge after the pin changes. The system clock must run at least four times the serial clock.
- R4: Instruction 0x06 sets the write-enable latch (status bit 1), and 0x04 clears it. After either one, further serial clocks are ignored until select rises.
- R5: Instruction 0x05 streams the status byte out MSB first. Bit 1 is the enable latch, bits 3:2 are the protection field and all other bits read 0. The same byte repeats for every further 8 clocks.
- R6: Instruction 0x01 takes one data byte. Bits 3:2 of that byte replace the protection field, and the enable latch and other bits are kept. The update does not need the enable latch.
- R7: An array write lands only while the enable latch is 1.
- R8: Protection field 00 allows every address. 01 blocks the top quarter of the array (two top address bits 11). 10 blocks the top half (top address bit 1). 11 blocks the whole array.
- R9: After each full write byte, the low 7 address bits increment with wrap-around and the upper bits stay, so a burst remains inside one 128-byte page. A write does not clear the enable latch.
- R10: Instructions 0x03 (read) and 0x02 (write) take a 16-bit address next, MSB first, masked to the array depth. For a read, each rising edge drives the next bit of the addressed byte, MSB first. After 8 bits the address increments modulo the array size and the next byte follows.
- R11: Any instruction other than 0x01 to 0x06 makes the block ignore the bus, with the data output unchanged, until select rises.
- R12: A side-port write (bd_we high) stores bd_wdata at bd_addr masked to the depth on the next clock edge. bd_rdata always shows the byte at bd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Hold, active low; freezes the block |
| miso | output | 1 | Serial data out of the block |
| bd_we | input | 1 | Side-port write strobe (test use) |
| bd_addr | input | 16 | Side-port byte address, masked to the depth |
| bd_wdata | input | 8 | Side-port write byte |
| bd_rdata | output | 8 | Side-port read byte at bd_addr |

## Verification
Every pin change takes effect on the third rising system-clock edge after it. The bench feeds its behavioural model the pin levels seen two edges earlier and compares the data output with the model at each falling system-clock edge, half a cycle after any update. The master samples the output a full half serial period (four system clocks) after each rising serial edge, well after the 2.5-cycle settling point, before it checks the bytes it received. Array contents go through the side port, whose read is combinational, and are sampled one time step after the address is set.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OP   = 3'd1,
    ST_ADDR = 3'd2,
    ST_WR   = 3'd3,
    ST_RD   = 3'd4
  } ee_state_t;

  localparam logic [7:0] OPC_SETPROT = 8'h01;
  localparam logic [7:0] OPC_WRITE   = 8'h02;
  localparam logic [7:0] OPC_READ    = 8'h03;
  localparam logic [7:0] OPC_WDIS    = 8'h04;
  localparam logic [7:0] OPC_GETSTAT = 8'h05;
  localparam logic [7:0] OPC_WEN     = 8'h06;

  // positions inside the synchronised pin vector
  localparam int PIN_MOSI = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_HOLD = 2;
  localparam int PIN_CS   = 3;
  localparam int PIN_N    = 4;
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1100;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] st1, st2, st3;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1[g] <= RST_VAL[g];
        st2[g] <= RST_VAL[g];
        st3[g] <= RST_VAL[g];
      end else begin
        st1[g] <= pin_i[g];
        st2[g] <= st1[g];
        st3[g] <= st2[g];
      end
    end
  end

  assign sync_o = st2;
  assign prev_o = st3;
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_wdata,
  output logic [7:0]    bd_rdata
);
  logic [7:0] cells [MEM_BYTES];

  // side port wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (bd_we)      cells[bd_addr] <= bd_wdata;
    else if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data  = cells[rd_addr];
  assign bd_rdata = cells[bd_addr];
endmodule

// File: rtl/spi_ee_fsm.sv
module spi_ee_fsm
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_s,
  input  logic          cs_s,
  input  logic          sck_rise,
  input  logic          din_s,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          dout,
  output logic [7:0]    status_o,
  output ee_state_t     state_o
);
  localparam logic [15:0] AMASK = 16'(MEM_BYTES - 1);

  ee_state_t   state_q;
  logic [3:0]  cnt_q;
  logic [7:0]  op_q;
  logic [7:0]  sh_q;
  logic [15:0] addr_q;
  logic        wen_q;
  logic [1:0]  prot_q;
  logic        dout_q;

  logic        step;
  logic [7:0]  op_n, sh_n;
  logic [15:0] addr_n, addr_inc, addr_page;
  logic [1:0]  top2;
  logic        wr_ok;

  assign step      = hold_s && !cs_s && sck_rise;
  assign op_n      = {op_q[6:0], din_s};
  assign sh_n      = {sh_q[6:0], din_s};
  assign addr_n    = {addr_q[14:0], din_s};
  assign addr_inc  = (addr_q + 16'd1) & AMASK;
  assign addr_page = {addr_q[15:7], addr_q[6:0] + 7'd1};
  assign top2      = addr_q[AW-1:AW-2];

  // protection fence against the masked address
  always_comb begin
    unique case (prot_q)
      2'b00:   wr_ok = 1'b1;
      2'b01:   wr_ok = (top2 != 2'b11);
      2'b10:   wr_ok = !addr_q[AW-1];
      default: wr_ok = 1'b0;
    endcase
  end

  assign mem_raddr = (state_q == ST_ADDR) ? addr_n[AW-1:0] : addr_inc[AW-1:0];
  assign mem_waddr = addr_q[AW-1:0];
  assign mem_wdata = sh_n;
  assign mem_we    = step && (state_q == ST_WR) && (cnt_q == 4'd7) &&
                     !op_q[0] && wen_q && wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      cnt_q   <= '0;
      op_q    <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wen_q   <= 1'b0;
      prot_q  <= 2'b00;
      dout_q  <= 1'b1;
    end else if (hold_s) begin
      if (cs_s) begin
        cnt_q   <= '0;
        op_q    <= '0;
        dout_q  <= 1'b1;
        state_q <= ST_OP;
      end else if (sck_rise) begin
        unique case (state_q)
          ST_OP: begin
            op_q <= op_n;
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              unique case (op_n)
                OPC_SETPROT: begin sh_q <= '0; state_q <= ST_WR; end
                OPC_WRITE, OPC_READ: begin addr_q <= '0; state_q <= ST_ADDR; end
                OPC_WDIS:    begin wen_q <= 1'b0; state_q <= ST_IDLE; end
                OPC_GETSTAT: begin sh_q <= {4'b0, prot_q, wen_q, 1'b0}; state_q <= ST_RD; end
                OPC_WEN:     begin wen_q <= 1'b1; state_q <= ST_IDLE; end
                default:     state_q <= ST_IDLE;
              endcase
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_ADDR: begin
            if (cnt_q == 4'd15) begin
              cnt_q  <= '0;
              addr_q <= addr_n & AMASK;
              if (op_q[0]) begin
                sh_q    <= mem_rdata;
                state_q <= ST_RD;
              end else begin
                sh_q    <= '0;
                state_q <= ST_WR;
              end
            end else begin
              cnt_q  <= cnt_q + 4'd1;
              addr_q <= addr_n;
            end
          end
          ST_WR: begin
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              if (op_q[0]) begin
                prot_q  <= sh_n[3:2];
                state_q <= ST_IDLE;
              end else begin
                sh_q   <= '0;
                addr_q <= addr_page;
              end
            end else begin
              cnt_q <= cnt_q + 4'd1;
              sh_q  <= sh_n;
            end
          end
          ST_RD: begin
            dout_q <= sh_q[~cnt_q[2:0]];
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              if (op_q == OPC_READ) begin
                addr_q <= addr_inc;
                sh_q   <= mem_rdata;
              end
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout     = dout_q;
  assign status_o = {4'b0, prot_q, wen_q, 1'b0};
  assign state_o  = state_q;
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  input  logic        hold_n,
  output logic        miso,
  input  logic        bd_we,
  input  logic [15:0] bd_addr,
  input  logic [7:0]  bd_wdata,
  output logic [7:0]  bd_rdata
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [PIN_N-1:0] pin_raw, pin_s, pin_p;
  logic             hold_s, cs_s, sck_rise;
  logic [AW-1:0]    mem_raddr, mem_waddr;
  logic [7:0]       mem_rdata, mem_wdata, status_q;
  logic             mem_we;
  ee_state_t        fsm_state;

  assign pin_raw[PIN_MOSI] = mosi;
  assign pin_raw[PIN_SCK]  = sck;
  assign pin_raw[PIN_HOLD] = hold_n;
  assign pin_raw[PIN_CS]   = cs_n;

  spi_ee_sync #(.W(PIN_N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_raw), .sync_o(pin_s), .prev_o(pin_p)
  );

  assign hold_s   = pin_s[PIN_HOLD];
  assign cs_s     = pin_s[PIN_CS];
  assign sck_rise = pin_s[PIN_SCK] && !pin_p[PIN_SCK];

  spi_ee_fsm #(.MEM_BYTES(MEM_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .cs_s(cs_s),
    .sck_rise(sck_rise), .din_s(pin_s[PIN_MOSI]),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .dout(miso),
    .status_o(status_q), .state_o(fsm_state)
  );

  spi_ee_array #(.MEM_BYTES(MEM_BYTES)) u_array (
    .clk(clk), .rd_addr(mem_raddr), .rd_data(mem_rdata),
    .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata),
    .bd_we(bd_we), .bd_addr(bd_addr[AW-1:0]), .bd_wdata(bd_wdata),
    .bd_rdata(bd_rdata)
  );
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_s,
  input logic          cs_s,
  input logic          miso,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [7:0]    status,
  input ee_state_t     state
);
  a_r1_hold_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> $stable(miso));

  a_r1_hold_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> $stable(state) && $stable(status));

  a_r1_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |-> !mem_we);

  a_r2_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s && cs_s |=> miso && state == ST_OP);

  a_r7_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> status[1]);

  a_r8_fence_respected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (status[3:2] != 2'b11) &&
               !(status[3:2] == 2'b10 && mem_waddr[AW-1]) &&
               !(status[3:2] == 2'b01 && mem_waddr[AW-1] && mem_waddr[AW-2]));
endmodule

bind spi_eeprom_slave spi_ee_checker #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .cs_s(cs_s), .miso(miso),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .status(status_q), .state(fsm_state)
);

// File: tb/tb_spi_eeprom_slave.sv
`timescale 1ns/100ps
module tb_spi_eeprom_slave;
  localparam int MEMN = 256;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic        miso;
  logic        bd_we = 1'b0;
  logic [15:0] bd_addr = '0;
  logic [7:0]  bd_wdata = '0;
  logic [7:0]  bd_rdata;

  int checks = 0, errors = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.MEM_BYTES(MEMN)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .miso(miso), .bd_we(bd_we), .bd_addr(bd_addr),
    .bd_wdata(bd_wdata), .bd_rdata(bd_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_state, m_cnt, m_op, m_buf, m_addr, m_status;
  bit m_out, m_clk;
  int model_mem [MEMN];
  bit [3:0] dl1, dl2;   // {cs, hold, sck, mosi} seen one and two edges ago

  task automatic model_step(input bit [3:0] p);
    bit d, c, h, s, rise, ok;
    d = p[0]; c = p[1]; h = p[2]; s = p[3];
    rise = c && !m_clk;
    if (h) begin
      if (s) begin
        m_cnt = 0; m_out = 1; m_op = 0; m_state = 1;
      end else if (rise) begin
        case (m_state)
          1: begin
            m_op = ((m_op << 1) | d) & 255; m_cnt++;
            if (m_cnt == 8) begin
              m_cnt = 0;
              case (m_op)
                1: begin m_buf = 0; m_state = 3; end
                2, 3: begin m_addr = 0; m_state = 2; end
                4: begin m_status = m_status & ~2; m_state = 0; end
                5: begin m_buf = m_status; m_state = 4; end
                6: begin m_status = m_status | 2; m_state = 0; end
                default: m_state = 0;
              endcase
            end
          end
          2: begin
            m_addr = ((m_addr << 1) | d) & 16'hFFFF; m_cnt++;
            if (m_cnt == 16) begin
              m_cnt = 0; m_addr = m_addr % MEMN;
              if (m_op & 1) begin m_buf = model_mem[m_addr]; m_state = 4; end
              else begin m_buf = 0; m_state = 3; end
            end
          end
          3: begin
            m_buf = ((m_buf << 1) | d) & 255; m_cnt++;
            if (m_cnt == 8) begin
              m_cnt = 0;
              if (m_op & 1) begin
                m_status = (m_status & 2) | (m_buf & 12); m_state = 0;
              end else begin
                if (m_status & 2) begin
                  case ((m_status >> 2) & 3)
                    0: ok = 1;
                    1: ok = m_addr < (3 * MEMN / 4);
                    2: ok = m_addr < (MEMN / 2);
                    default: ok = 0;
                  endcase
                  if (ok) model_mem[m_addr] = m_buf;
                end
                m_buf = 0;
                m_addr = (m_addr & ~127) | ((m_addr + 1) & 127);
              end
            end
          end
          4: begin
            m_out = (m_buf >> (7 - m_cnt)) & 1; m_cnt++;
            if (m_cnt == 8) begin
              m_cnt = 0;
              if (m_op == 3) begin
                m_addr = (m_addr + 1) % MEMN; m_buf = model_mem[m_addr];
              end
            end
          end
          default: ;
        endcase
      end
    end
    m_clk = c;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 1; m_cnt = 0; m_op = 0; m_buf = 0; m_addr = 0; m_status = 0;
      m_out = 1; m_clk = 0; dl1 = 4'b1100; dl2 = 4'b1100;
    end else begin
      model_step(dl2);
      dl2 = dl1;
      dl1 = {cs_n, hold_n, sck, mosi};
    end
  end

  // output compared with the model half a cycle after each update (R3 timing)
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (miso !== m_out) begin
        errors++;
        $display("FAIL %s/R3 miso per-cycle actual %b expected %b at %0t",
                 cur_req, miso, m_out, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_at);
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        hold_n = 1'b0; waitn(HALF);
        for (int k = 0; k < 3; k++) begin
          mosi = 1'b1; sck = 1'b1; waitn(HALF); sck = 1'b0; waitn(HALF);
        end
        hold_n = 1'b1; waitn(HALF);
      end
      mosi = tx[i]; waitn(HALF);
      sck = 1'b1; waitn(HALF);
      rx[i] = miso; sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; waitn(HALF);
  endtask

  task automatic desel();
    waitn(HALF); cs_n = 1'b1; waitn(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r, -1); desel();
  endtask

  task automatic wr_burst(input logic [15:0] a, input logic [7:0] d0,
                          input logic [7:0] d1, input int n);
    logic [7:0] r;
    sel(); xfer(8'h02, r, -1); xfer(a[15:8], r, -1); xfer(a[7:0], r, -1);
    xfer(d0, r, -1);
    if (n > 1) xfer(d1, r, -1);
    desel();
  endtask

  task automatic set_prot(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r, -1); xfer(v, r, -1); desel();
  endtask

  task automatic rd_status(input string req, input logic [7:0] exp);
    logic [7:0] r;
    sel(); xfer(8'h05, r, -1);
    xfer(8'h00, r, -1); chk(req, r, exp);
    xfer(8'h00, r, -1); chk({req, " repeat"}, r, exp);
    desel();
  endtask

  task automatic bd_peek(input string req, input logic [15:0] a, input logic [7:0] exp);
    bd_addr = a; #1;
    chk(req, bd_rdata, exp);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] r;
    waitn(4);
    rst_n = 1'b1;
    waitn(2);
    chk("R2 output high after reset", {7'b0, miso}, 8'h01);
    cmp_en = 1;

    // R12: side-port preload
    cur_req = "R12";
    for (int a = 0; a < MEMN; a++) begin
      bd_we = 1'b1; bd_addr = 16'(a); bd_wdata = 8'(a) ^ 8'h5A;
      model_mem[a] = (a ^ 8'h5A) & 255;
      @(negedge clk);
    end
    bd_we = 1'b0;
    bd_peek("R12 side read", 16'h0033, 8'h33 ^ 8'h5A);

    cur_req = "R5";
    rd_status("R5 status after reset", 8'h00);

    cur_req = "R7";
    wr_burst(16'h0010, 8'hAA, 8'h00, 1);

    cur_req = "R4";
    sel(); xfer(8'h06, r, -1); xfer(8'hFF, r, -1); desel();
    rd_status("R4 enable latch set", 8'h02);

    cur_req = "R9";
    wr_burst(16'h007E, 8'h11, 8'h22, 2);
    wr_burst(16'h007F, 8'h22, 8'h33, 2);
    rd_status("R9 latch kept after write", 8'h02);

    cur_req = "R6";
    set_prot(8'hFF);
    rd_status("R6 protection field set", 8'h0E);
    cur_req = "R8";
    wr_burst(16'h0020, 8'h77, 8'h00, 1);
    set_prot(8'h04);
    wr_burst(16'h00BF, 8'h44, 8'h55, 2);
    set_prot(8'h08);
    wr_burst(16'h007F, 8'h66, 8'h67, 2);
    wr_burst(16'h0080, 8'h99, 8'h00, 1);

    cur_req = "R4";
    cmd1(8'h04);
    rd_status("R4 latch cleared, field kept", 8'h08);
    cur_req = "R6";
    set_prot(8'h00);
    rd_status("R6 field cleared without latch", 8'h00);
    cur_req = "R7";
    wr_burst(16'h0030, 8'h12, 8'h00, 1);
    cur_req = "R6";
    cmd1(8'h06);
    set_prot(8'h03);
    rd_status("R6 only bits 3:2 taken", 8'h02);

    cur_req = "R10";
    sel(); xfer(8'h03, r, -1); xfer(8'h12, r, -1); xfer(8'hFE, r, -1);
    xfer(8'h00, r, -1); chk("R10 read at FE (masked)", r, 8'hA4);
    xfer(8'h00, r, -1); chk("R10 read at FF", r, 8'hA5);
    xfer(8'h00, r, -1); chk("R10 read wraps to 00", r, 8'h67);
    xfer(8'h00, r, -1); chk("R10 read at 01", r, 8'h5B);
    desel();

    cur_req = "R11";
    sel(); xfer(8'h9F, r, -1); xfer(8'h00, r, -1);
    chk("R11 undefined opcode keeps output high", r, 8'hFF);
    desel();
    rd_status("R11 status untouched", 8'h02);

    cur_req = "R1";
    sel(); xfer(8'h02, r, -1); xfer(8'h00, r, -1); xfer(8'h40, r, -1);
    xfer(8'hC3, r, 3); desel();

    cur_req = "R2";
    sel(); xfer(8'h02, r, -1); xfer(8'h00, r, -1); xfer(8'h41, r, -1);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b0; waitn(HALF); sck = 1'b1; waitn(HALF); sck = 1'b0;
    end
    desel();
    sel(); xfer(8'h03, r, -1); xfer(8'h00, r, -1); xfer(8'h00, r, -1);
    for (int i = 0; i < 3; i++) begin
      waitn(HALF); sck = 1'b1; waitn(HALF); sck = 1'b0;
    end
    desel();
    chk("R2 output high after aborted read", {7'b0, miso}, 8'h01);

    cmp_en = 0;
    bd_peek("R7 write without latch dropped", 16'h0010, 8'h4A);
    bd_peek("R9 first page byte", 16'h007E, 8'h11);
    bd_peek("R8 half fence allows 7F", 16'h007F, 8'h66);
    bd_peek("R9 burst wraps to page start", 16'h0000, 8'h67);
    bd_peek("R8 all blocked", 16'h0020, 8'h7A);
    bd_peek("R8 quarter fence allows BF", 16'h00BF, 8'h44);
    bd_peek("R8 quarter fence blocks C0", 16'h00C0, 8'h9A);
    bd_peek("R8 half fence blocks 80", 16'h0080, 8'hDA);
    bd_peek("R7 write after disable dropped", 16'h0030, 8'h6A);
    bd_peek("R1 byte intact across hold", 16'h0040, 8'hC3);
    bd_peek("R2 aborted write no effect", 16'h0041, 8'h1B);
    for (int a = 0; a < MEMN; a++) begin
      bd_addr = 16'(a); #1;
      chk("R12 array matches model", bd_rdata, 8'(model_mem[a]));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule